// File: doc/BRIEF.md
# Shift, Rotate and Bit-Count Unit

This block is a purely combinational datapath slice for a 32-bit integer core. It takes an operand, a shift amount held in a register, a three-bit operation code and the current carry flag. It returns one result word together with negative, zero and carry flags. It performs four shift or rotate operations (left logical, right logical, right arithmetic and right rotate), a leading-zero count and a bit reversal.

Each shift operation accepts its own legal range of amounts. The unit decides, for every operation and amount, whether the flags are to be written back. It raises `flags_we_o` for a legal shift or rotate. The two bit-count operations and any illegal request leave the stored flags alone, and in those cases the unit passes the incoming carry straight to `carry_o`. A trailing-zero count is made by running the bit reversal first and then the leading-zero count on its output.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation code 0 is a left logical shift. For an amount k from 1 to 31 the result is the operand moved left by k with zeros filled in, `carry_o` is operand bit 32-k, and `flags_we_o` is 1.
- R2: A left logical shift with amount 0 returns the operand unchanged. `carry_o` equals `carry_i` and `flags_we_o` is 1.
- R3: Operation code 1 is a right logical shift for k from 1 to 32. It fills with zeros, sets `carry_o` to operand bit k-1 and sets `flags_we_o` to 1. With k = 32 the result is 0 and the carry is bit 31.
- R4: Operation code 2 is a right arithmetic shift for k from 1 to 32. It fills with copies of bit 31, sets `carry_o` to operand bit k-1 and sets `flags_we_o` to 1. With k = 32 every result bit equals operand bit 31.
- R5: Operation code 3 rotates right for k from 1 to 31: result bit i is operand bit (i+k) mod 32. `carry_o` is operand bit k-1 and `flags_we_o` is 1.
- R6: Operation code 4 returns the count of zero bits above the highest set bit, and 32 for a zero operand. `flags_we_o` is 0 and `carry_o` equals `carry_i`.
- R7: Operation code 5 places operand bit i at result bit 31-i. `flags_we_o` is 0 and `carry_o` equals `carry_i`.
- R8: For every operation, `neg_o` equals result bit 31 and `zero_o` is 1 exactly when the result is 0.
- R9: An amount outside the legal range of a shift code, or either of the unused codes 6 and 7, returns the operand unchanged. In those cases `flags_we_o` is 0 and `carry_o` equals `carry_i`.
- R10: Applying code 4 to the output of code 5 yields the trailing-zero count of the operand, and 32 for zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 32 | Operand |
| amount_i | input | 6 | Shift or rotate amount, unsigned |
| op_i | input | 3 | Operation code (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right, 4 leading zeros, 5 bit reverse) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Result word |
| neg_o | output | 1 | Negative flag for the result |
| zero_o | output | 1 | Zero flag for the result |
| carry_o | output | 1 | Carry flag for the result |
| flags_we_o | output | 1 | Flags are to be written back |

## Verification
The assertions are evaluated whenever an input changes. They check that the bit-count codes never request a flag write and keep the carry, and that illegal amounts and unused codes pass the operand through. They also check the fill bit of the right shifts, the zero-only case of the leading-zero count, and the end bits of a bit reversal. The exact bit placement for every amount, the source bit of the carry, and the amount-32 corners can only be shown by the bench. The bench sweeps every code and every amount from 0 to 63 over a set of operands. The same holds for the chained trailing-zero count.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic [AW-1:0]    amount_i,
  input  logic [2:0]       op_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             flags_we_o
);

  localparam logic [2:0] OP_SHL = 3'd0;
  localparam logic [2:0] OP_SHR = 3'd1;
  localparam logic [2:0] OP_SAR = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_LZC = 3'd4;
  localparam logic [2:0] OP_REV = 3'd5;
  localparam logic [AW-1:0] WL = AW'(WIDTH);

  logic [AW-1:0]    k;
  logic             k_nz, k_lt, k_le;
  logic [AW-1:0]    out_sel;
  logic             out_bit;
  logic [WIDTH-1:0] rev;
  logic [AW-1:0]    lzc;

  assign k    = amount_i;
  assign k_nz = (k != '0);
  assign k_lt = (k < WL);
  assign k_le = (k <= WL);

  assign out_sel = (op_i == OP_SHL) ? (WL - k) : (k - 1'b1);
  assign out_bit = value_i[out_sel[AW-2:0]];

  always_comb begin
    for (int i = 0; i < WIDTH; i++) rev[i] = value_i[WIDTH-1-i];
  end

  always_comb begin
    lzc = WL;
    for (int i = 0; i < WIDTH; i++)
      if (value_i[i]) lzc = AW'(WIDTH - 1 - i);
  end

  always_comb begin
    result_o   = value_i;
    carry_o    = carry_i;
    flags_we_o = 1'b0;
    unique case (op_i)
      OP_SHL: if (k_lt) begin
        result_o   = value_i << k;
        carry_o    = k_nz ? out_bit : carry_i;
        flags_we_o = 1'b1;
      end
      OP_SHR: if (k_nz && k_le) begin
        result_o   = value_i >> k;
        carry_o    = out_bit;
        flags_we_o = 1'b1;
      end
      OP_SAR: if (k_nz && k_le) begin
        result_o   = $unsigned($signed(value_i) >>> k);
        carry_o    = out_bit;
        flags_we_o = 1'b1;
      end
      OP_ROR: if (k_nz && k_lt) begin
        result_o   = (value_i >> k) | (value_i << (WL - k));
        carry_o    = out_bit;
        flags_we_o = 1'b1;
      end
      OP_LZC: result_o = WIDTH'(lzc);
      OP_REV: result_o = rev;
      default: ;
    endcase
  end

  assign neg_o  = result_o[WIDTH-1];
  assign zero_o = ~|result_o;

endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH) + 1
) (
  input logic [WIDTH-1:0] value_i,
  input logic [AW-1:0]    amount_i,
  input logic [2:0]       op_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             neg_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             flags_we_o
);
  localparam logic [AW-1:0] WL = AW'(WIDTH);

  logic known;
  assign known = !$isunknown({value_i, amount_i, op_i, carry_i});

  always_comb begin
    if (known) begin
      // R6
      lzc_flags_chk: assert (op_i != 3'd4 || (!flags_we_o && carry_o == carry_i))
        else $error("lzc touched flags");
      // R6
      lzc_zero_chk: assert (op_i != 3'd4 || ((value_i == '0) == (result_o == WIDTH'(WIDTH))))
        else $error("lzc zero case");
      // R7
      rev_flags_chk: assert (op_i != 3'd5 || (!flags_we_o && carry_o == carry_i &&
                              result_o[0] == value_i[WIDTH-1] && result_o[WIDTH-1] == value_i[0]))
        else $error("reverse wrong");
      // R3
      shr_fill_chk: assert (!(op_i == 3'd1 && amount_i != '0 && amount_i <= WL) || !result_o[WIDTH-1])
        else $error("shr fill");
      // R4
      sar_fill_chk: assert (!(op_i == 3'd2 && amount_i != '0 && amount_i <= WL) ||
                            result_o[WIDTH-1] == value_i[WIDTH-1])
        else $error("sar fill");
      // R2
      shl_zero_chk: assert (!(op_i == 3'd0 && amount_i == '0) ||
                            (result_o == value_i && carry_o == carry_i && flags_we_o))
        else $error("shl by zero");
      // R9
      bad_op_chk: assert (!(op_i[2:1] == 2'b11) ||
                          (result_o == value_i && !flags_we_o && carry_o == carry_i))
        else $error("unused code");
      // R9
      bad_amt_chk: assert (!((op_i == 3'd0 && amount_i >= WL) ||
                             (op_i == 3'd3 && (amount_i == '0 || amount_i >= WL)) ||
                             ((op_i == 3'd1 || op_i == 3'd2) && (amount_i == '0 || amount_i > WL))) ||
                           (result_o == value_i && !flags_we_o && carry_o == carry_i))
        else $error("illegal amount");
      // R8
      neg_flag_chk: assert (neg_o == result_o[WIDTH-1] && zero_o == (result_o == '0))
        else $error("nz flags");
    end
  end
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .value_i(value_i), .amount_i(amount_i), .op_i(op_i), .carry_i(carry_i),
  .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o), .carry_o(carry_o),
  .flags_we_o(flags_we_o)
);

// File: tb/shift_rot_unit_bench.sv
`timescale 1ns/1ps
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic [31:0] value_i = '0;
  logic [5:0]  amount_i = '0;
  logic [2:0]  op_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        neg_o, zero_o, carry_o, flags_we_o;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .value_i(value_i), .amount_i(amount_i), .op_i(op_i), .carry_i(carry_i),
    .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o), .carry_o(carry_o),
    .flags_we_o(flags_we_o)
  );

  function automatic logic [31:0] pick(int n);
    case (n)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_0001;
      4: return 32'h7FFF_FFFF;
      5: return 32'hA5A5_5A5A;
      6: return 32'h0001_0000;
      7: return 32'h8000_0001;
      default: return (32'(n) * 32'h9E37_79B9) ^ (32'(n) << 13);
    endcase
  endfunction

  task automatic model(input logic [31:0] v, input int op, input int k, input logic cin,
                       output logic [31:0] r, output logic c, output logic we, output string tag);
    bit ok;
    r = v; c = cin; we = 0; ok = 0;
    case (op)
      0: begin tag = (k == 0) ? "R2" : "R1"; ok = (k <= 31); end
      1: begin tag = "R3"; ok = (k >= 1 && k <= 32); end
      2: begin tag = "R4"; ok = (k >= 1 && k <= 32); end
      3: begin tag = "R5"; ok = (k >= 1 && k <= 31); end
      4: tag = "R6";
      5: tag = "R7";
      default: tag = "R9";
    endcase
    if (op <= 3 && !ok) tag = "R9";
    if (op <= 3 && ok) begin
      we = 1;
      for (int i = 0; i < 32; i++) begin
        case (op)
          0: r[i] = (i >= k) ? v[i-k] : 1'b0;
          1: r[i] = (i + k < 32) ? v[i+k] : 1'b0;
          2: r[i] = (i + k < 32) ? v[i+k] : v[31];
          default: r[i] = v[(i+k) % 32];
        endcase
      end
      c = (op == 0) ? ((k == 0) ? cin : v[32-k]) : v[k-1];
    end else if (op == 4) begin
      int cnt = 32;
      for (int i = 31; i >= 0; i--) if (v[i]) begin cnt = 31 - i; break; end
      r = 32'(cnt);
    end else if (op == 5) begin
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
    end
  endtask

  task automatic apply(input logic [31:0] v, input int op, input int k, input logic cin);
    @(posedge clk);
    value_i = v; op_i = 3'(op); amount_i = 6'(k); carry_i = cin;
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] er, rv;
    logic ec, ew;
    string tag;
    for (int n = 0; n < 24; n++) begin
      logic [31:0] v = pick(n);
      for (int op = 0; op < 8; op++) begin
        for (int k = 0; k < 64; k++) begin
          logic cin = 1'((n + k + op) & 1);
          apply(v, op, k, cin);
          model(v, op, k, cin, er, ec, ew, tag);
          tests++;
          if (result_o !== er || carry_o !== ec || flags_we_o !== ew) begin
            fails++;
            $display("FAIL %s op=%0d k=%0d v=%h: actual r=%h c=%b we=%b expected r=%h c=%b we=%b",
                     tag, op, k, v, result_o, carry_o, flags_we_o, er, ec, ew);
          end
          tests++;
          if (neg_o !== er[31] || zero_o !== (er == 0)) begin
            fails++;
            $display("FAIL R8 op=%0d k=%0d: actual n=%b z=%b expected n=%b z=%b",
                     op, k, neg_o, zero_o, er[31], er == 0);
          end
        end
      end
      // R10: trailing zeros via reverse then leading-zero count
      apply(v, 5, 0, 1'b0);
      rv = result_o;
      apply(rv, 4, 0, 1'b0);
      begin
        int tz = 32;
        for (int i = 0; i < 32; i++) if (v[i]) begin tz = i; break; end
        tests++;
        if (result_o !== 32'(tz)) begin
          fails++;
          $display("FAIL R10 v=%h: actual %0d expected %0d", v, result_o, tz);
        end
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule